// File: doc/BRIEF.md
# Address Table Command Engine

This block holds a small table of MAC address entries and serves it through a command-and-status register set. Software loads the three entry data words, then writes the command word with its busy bit set and an operation code. It then polls the command word until busy drops. Five operations are provided: write (insert, overwrite or erase), read, flush, search-start and search-next. A read or a search hit places the entry in the data words. Result flags for invalid, hit and end are reported next to the busy bit.

Entries are keyed on the 48-bit MAC address together with the 12-bit VLAN ID. There is no hashing. Every read and write walks all slots in order, one slot per clock. This puts a fixed and short bound on every command. A search resumes from the slot after its last hit, so software can list the table with one search-start followed by search-next until the end flag appears. Entries carry an age value, but nothing ages them, and nothing learns addresses from traffic.

Top module: `atc_engine`

## Requirements
- R1: After reset the four registers read as zero. The table is empty and no search is in progress, so search-next reports end.
- R2: Writing address 0 while idle with bit 31 set starts the operation whose code is in bits 2:0: 0 read, 1 write, 2 flush, 4 search-start, 5 search-next. Bit 31 then reads 1 until the operation finishes, which takes at most DEPTH+1 cycles. Writing address 0 with bit 31 clear starts nothing and changes nothing.
- R3: While bit 31 reads 1, host writes to every address are ignored.
- R4: Write compares the key (MAC and VLAN ID) against all valid slots. A matching slot is overwritten. Otherwise the lowest-numbered free slot takes the entry. The table changes only as the result of a command.
- R5: Write with status 00 erases the valid slot that matches the key. If no slot matches, nothing changes and no flag is set.
- R6: Write of a new key while every slot is valid sets the invalid flag (bit 12) and leaves the table unchanged.
- R7: Read of a present key loads its entry into the three data words. Read of an absent key sets the invalid flag and leaves the data words unchanged.
- R8: Flush keeps busy for exactly one cycle and empties the table.
- R9: Search-start examines slots from 0. Search-next examines slots from the one after the last hit. The first valid slot found sets the hit flag (bit 13) and loads its entry into the data words.
- R10: A search that finds no further valid slot sets the end flag (bit 14), clears hit and leaves the data words unchanged. Hit and end are never set together. Every command clears all three flags when it starts.
- R11: Address 1 holds MAC bytes 0 to 3, with byte 0 in bits 31:24. Address 2 holds MAC bytes 4 and 5 in bits 31:16 and the VLAN ID in bits 11:0. Address 3 holds the age in bits 31:24, the port map in bits 23:16 and the status in bits 1:0 (00 empty, 01 dynamic, 11 static). Words loaded from the table read zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 to 3 entry words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
Some properties are checked by the assertions on every cycle. A command that is started always raises busy. A write with bit 31 clear never does. Busy never lasts longer than DEPTH+1 cycles. The operation code holds while host writes arrive during busy. Flush drops busy after one cycle with every slot empty. Hit and end never appear together. The valid slots never change while the engine is idle.

The correctness of entry contents depends on the history of earlier commands, so only the bench scenarios can show it. This covers overwrite versus first-free placement, erase of present and absent keys, the full-table rejection, and the order a search walk visits slots after erases. The bench shows these by comparing every register after every command against a reference table model.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int AGE_W  = 8;
  localparam int PMAP_W = 8;
  localparam int ST_W   = 2;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_WRITE  = 3'd1;
  localparam logic [2:0] OP_FLUSH  = 3'd2;
  localparam logic [2:0] OP_SFIRST = 3'd4;
  localparam logic [2:0] OP_SNEXT  = 3'd5;

  localparam logic [ST_W-1:0] ST_EMPTY = 2'b00;

  localparam int BIT_BUSY = 31;
  localparam int BIT_END  = 14;
  localparam int BIT_HIT  = 13;
  localparam int BIT_INV  = 12;

  typedef struct packed {
    logic [MAC_W-1:0]  mac;
    logic [VID_W-1:0]  vid;
    logic [AGE_W-1:0]  age;
    logic [PMAP_W-1:0] pmap;
    logic [ST_W-1:0]   st;
  } ent_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_APPLY, S_FLUSH, S_FIN
  } eng_st_e;
endpackage

// File: rtl/atc_store.sv
module atc_store
  import atc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DEPTH)-1:0]  wr_idx,
  input  ent_t                      wr_ent,
  input  logic                      clr_all,
  input  logic [$clog2(DEPTH)-1:0]  rd_idx,
  output ent_t                      rd_ent,
  output logic                      rd_vld,
  output logic [DEPTH-1:0]          vld_vec
);
  logic [DEPTH-1:0] vld_q;
  ent_t             ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= (wr_ent.st != ST_EMPTY);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  assign rd_ent  = ent_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign vld_vec = vld_q;
endmodule

// File: rtl/atc_keycmp.sv
module atc_keycmp
  import atc_pkg::*;
(
  input  ent_t             slot,
  input  logic             slot_vld,
  input  logic [MAC_W-1:0] key_mac,
  input  logic [VID_W-1:0] key_vid,
  output logic             key_hit
);
  assign key_hit = slot_vld && (slot.mac == key_mac) && (slot.vid == key_vid);
endmodule

// File: rtl/atc_ctrl.sv
module atc_ctrl
  import atc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [1:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic [$clog2(DEPTH)-1:0]  slot_idx,
  input  ent_t                      slot_ent,
  input  logic                      slot_vld,
  input  logic                      slot_hit,
  output logic [MAC_W-1:0]          key_mac,
  output logic [VID_W-1:0]          key_vid,
  output logic                      tbl_we,
  output logic [$clog2(DEPTH)-1:0]  tbl_idx,
  output ent_t                      tbl_ent,
  output logic                      tbl_clr,
  output logic [31:0]               cmd_word
);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);
  localparam logic [IDXW:0]   END_PTR  = (IDXW + 1)'(DEPTH);

  eng_st_e          state_q, state_d;
  logic [2:0]       code_q, code_d;
  logic [IDXW-1:0]  idx_q, idx_d;
  logic             fnd_q, fnd_d;
  logic [IDXW-1:0]  fidx_q, fidx_d;
  logic             fre_q, fre_d;
  logic [IDXW-1:0]  freidx_q, freidx_d;
  logic [IDXW:0]    nxt_q, nxt_d;
  logic             inv_q, inv_d, hit_q, hit_d, end_q, end_d;
  logic [31:0]      w0_q, w0_d, w1_q, w1_d, w2_q, w2_d;
  logic             busy, host_cmd, is_search;

  assign busy      = (state_q != S_IDLE);
  assign host_cmd  = reg_we && (reg_addr == 2'd0) && reg_wdata[BIT_BUSY];
  assign is_search = (code_q == OP_SFIRST) || (code_q == OP_SNEXT);

  assign key_mac = {w0_q, w1_q[31:16]};
  assign key_vid = w1_q[VID_W-1:0];
  assign slot_idx = (state_q == S_APPLY) ? fidx_q : idx_q;

  always_comb begin
    tbl_ent      = '0;
    tbl_ent.mac  = {w0_q, w1_q[31:16]};
    tbl_ent.vid  = w1_q[VID_W-1:0];
    tbl_ent.age  = w2_q[31:24];
    tbl_ent.pmap = w2_q[23:16];
    tbl_ent.st   = w2_q[ST_W-1:0];
  end

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    idx_d    = idx_q;
    fnd_d    = fnd_q;
    fidx_d   = fidx_q;
    fre_d    = fre_q;
    freidx_d = freidx_q;
    nxt_d    = nxt_q;
    inv_d    = inv_q;
    hit_d    = hit_q;
    end_d    = end_q;
    w0_d     = w0_q;
    w1_d     = w1_q;
    w2_d     = w2_q;
    tbl_we   = 1'b0;
    tbl_idx  = idx_q;
    tbl_clr  = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (reg_we) begin
          unique case (reg_addr)
            2'd1: w0_d = reg_wdata;
            2'd2: w1_d = reg_wdata;
            2'd3: w2_d = reg_wdata;
            default: ;
          endcase
        end
        if (host_cmd) begin
          code_d = reg_wdata[2:0];
          inv_d  = 1'b0;
          hit_d  = 1'b0;
          end_d  = 1'b0;
          fnd_d  = 1'b0;
          fre_d  = 1'b0;
          idx_d  = '0;
          unique case (reg_wdata[2:0])
            OP_READ, OP_WRITE, OP_SFIRST: state_d = S_SCAN;
            OP_FLUSH: state_d = S_FLUSH;
            OP_SNEXT: begin
              if (nxt_q == END_PTR) begin
                end_d   = 1'b1;
                state_d = S_FIN;
              end else begin
                idx_d   = nxt_q[IDXW-1:0];
                state_d = S_SCAN;
              end
            end
            default: state_d = S_FIN;
          endcase
        end
      end

      S_SCAN: begin
        if (is_search) begin
          if (slot_vld) begin
            hit_d   = 1'b1;
            w0_d    = slot_ent.mac[47:16];
            w1_d    = {slot_ent.mac[15:0], 4'h0, slot_ent.vid};
            w2_d    = {slot_ent.age, slot_ent.pmap, 14'h0, slot_ent.st};
            nxt_d   = {1'b0, idx_q} + 1'b1;
            state_d = S_IDLE;
          end else if (idx_q == LAST_IDX) begin
            end_d   = 1'b1;
            nxt_d   = END_PTR;
            state_d = S_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          if (slot_hit && !fnd_q) begin
            fnd_d  = 1'b1;
            fidx_d = idx_q;
          end
          if (!slot_vld && !fre_q) begin
            fre_d    = 1'b1;
            freidx_d = idx_q;
          end
          if (idx_q == LAST_IDX) state_d = S_APPLY;
          else                   idx_d   = idx_q + 1'b1;
        end
      end

      S_APPLY: begin
        state_d = S_IDLE;
        if (code_q == OP_READ) begin
          if (fnd_q) begin
            w0_d = slot_ent.mac[47:16];
            w1_d = {slot_ent.mac[15:0], 4'h0, slot_ent.vid};
            w2_d = {slot_ent.age, slot_ent.pmap, 14'h0, slot_ent.st};
          end else begin
            inv_d = 1'b1;
          end
        end else if (tbl_ent.st == ST_EMPTY) begin
          if (fnd_q) begin
            tbl_we  = 1'b1;
            tbl_idx = fidx_q;
          end
        end else if (fnd_q) begin
          tbl_we  = 1'b1;
          tbl_idx = fidx_q;
        end else if (fre_q) begin
          tbl_we  = 1'b1;
          tbl_idx = freidx_q;
        end else begin
          inv_d = 1'b1;
        end
      end

      S_FLUSH: begin
        tbl_clr = 1'b1;
        state_d = S_IDLE;
      end

      S_FIN: state_d = S_IDLE;

      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      code_q   <= '0;
      idx_q    <= '0;
      fnd_q    <= 1'b0;
      fidx_q   <= '0;
      fre_q    <= 1'b0;
      freidx_q <= '0;
      nxt_q    <= END_PTR;
      inv_q    <= 1'b0;
      hit_q    <= 1'b0;
      end_q    <= 1'b0;
      w0_q     <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_d;
      idx_q    <= idx_d;
      fnd_q    <= fnd_d;
      fidx_q   <= fidx_d;
      fre_q    <= fre_d;
      freidx_q <= freidx_d;
      nxt_q    <= nxt_d;
      inv_q    <= inv_d;
      hit_q    <= hit_d;
      end_q    <= end_d;
      w0_q     <= w0_d;
      w1_q     <= w1_d;
      w2_q     <= w2_d;
    end
  end

  assign cmd_word = {busy, 16'h0, end_q, hit_q, inv_q, 9'h0, code_q};

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = cmd_word;
      2'd1:    reg_rdata = w0_q;
      2'd2:    reg_rdata = w1_q;
      default: reg_rdata = w2_q;
    endcase
  end
endmodule

// File: rtl/atc_engine.sv
module atc_engine
  import atc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IDXW = $clog2(DEPTH);

  logic [IDXW-1:0]  slot_idx, tbl_idx;
  ent_t             slot_ent, tbl_ent;
  logic             slot_vld, slot_hit, tbl_we, tbl_clr;
  logic [MAC_W-1:0] key_mac;
  logic [VID_W-1:0] key_vid;
  logic [DEPTH-1:0] vld_vec;
  logic [31:0]      cmd_word;

  atc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_idx(slot_idx), .slot_ent(slot_ent), .slot_vld(slot_vld), .slot_hit(slot_hit),
    .key_mac(key_mac), .key_vid(key_vid),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_ent(tbl_ent), .tbl_clr(tbl_clr),
    .cmd_word(cmd_word)
  );

  atc_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_ent(tbl_ent), .clr_all(tbl_clr),
    .rd_idx(slot_idx), .rd_ent(slot_ent), .rd_vld(slot_vld), .vld_vec(vld_vec)
  );

  atc_keycmp u_cmp (
    .slot(slot_ent), .slot_vld(slot_vld),
    .key_mac(key_mac), .key_vid(key_vid), .key_hit(slot_hit)
  );
endmodule

// File: rtl/atc_engine_chk.sv
module atc_engine_chk
  import atc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      cmd_word,
  input logic [DEPTH-1:0] vld_vec
);
  localparam int CW = $clog2(DEPTH + 2) + 1;

  logic          busy, start;
  logic [CW-1:0] bcnt_q;

  assign busy  = cmd_word[BIT_BUSY];
  assign start = reg_we && (reg_addr == 2'd0) && reg_wdata[BIT_BUSY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + 1'b1;
    else           bcnt_q <= '0;
  end

  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R2
  AST_NO_FLAG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 2'd0 && !reg_wdata[BIT_BUSY]) |=> !busy); // R2
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt_q <= CW'(DEPTH))); // R2
  AST_CODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 2'd0) |=> (cmd_word[2:0] == $past(cmd_word[2:0]))); // R3
  AST_TABLE_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(vld_vec)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && reg_wdata[2:0] == OP_FLUSH) |=> busy ##1 (!busy && vld_vec == '0)); // R8
  AST_HIT_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_word[BIT_HIT] && cmd_word[BIT_END])); // R10
endmodule

bind atc_engine atc_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_word(cmd_word), .vld_vec(vld_vec)
);

// File: tb/atc_engine_bench.sv
`timescale 1ns/1ps
module atc_engine_bench;
  localparam int DEPTH = 16;
  localparam logic [31:0] M1 = 32'hFFFF_0FFF;
  localparam logic [31:0] M2 = 32'hFFFF_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;

  int nchk = 0;
  int nfail = 0;

  bit          mv [DEPTH];
  logic [31:0] m0 [DEPTH];
  logic [31:0] m1 [DEPTH];
  logic [31:0] m2 [DEPTH];
  int          mnxt = DEPTH;
  logic [31:0] d0 = 0, d1 = 0, d2 = 0;
  logic [2:0]  ecode = 0;
  logic        einv = 0, ehit = 0, eend = 0;

  atc_engine #(.DEPTH(DEPTH)) u_atc_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int find_key(logic [31:0] k0, logic [31:0] k1);
    for (int i = 0; i < DEPTH; i++)
      if (mv[i] && m0[i] == k0 && m1[i][31:16] == k1[31:16] && m1[i][11:0] == k1[11:0])
        return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < DEPTH; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_cmd();
    return {1'b0, 16'h0, eend, ehit, einv, 9'h0, ecode};
  endfunction

  task automatic model_cmd(logic [2:0] code);
    int k, f;
    ecode = code; einv = 0; ehit = 0; eend = 0;
    k = find_key(d0, d1);
    case (code)
      3'd0: if (k >= 0) begin d0 = m0[k]; d1 = m1[k]; d2 = m2[k]; end else einv = 1;
      3'd1: begin
        if (d2[1:0] == 2'b00) begin
          if (k >= 0) mv[k] = 0;
        end else begin
          f = (k >= 0) ? k : first_free();
          if (f < 0) einv = 1;
          else begin mv[f] = 1; m0[f] = d0; m1[f] = d1 & M1; m2[f] = d2 & M2; end
        end
      end
      3'd2: for (int i = 0; i < DEPTH; i++) mv[i] = 0;
      3'd4, 3'd5: begin
        int s;
        s = (code == 3'd4) ? 0 : mnxt;
        eend = 1;
        for (int i = s; i < DEPTH; i++) begin
          if (mv[i]) begin
            d0 = m0[i]; d1 = m1[i]; d2 = m2[i];
            ehit = 1; eend = 0; mnxt = i + 1;
            break;
          end
        end
        if (eend) mnxt = DEPTH;
      end
      default: ;
    endcase
  endtask

  task automatic run(logic [2:0] code);
    logic [31:0] v;
    int n;
    wr(2'd0, 32'h8000_0000 | {29'h0, code});
    n = 0;
    rd(2'd0, v);
    while (v[31] && n < 64) begin
      @(negedge clk);
      rd(2'd0, v);
      n++;
    end
    chk("R2 busy clears in bound", {31'h0, v[31]}, 32'h0);
    model_cmd(code);
  endtask

  task automatic chk_all(string req);
    logic [31:0] v;
    rd(2'd0, v); chk({req, " cmd"}, v, exp_cmd());
    rd(2'd1, v); chk({req, " w0"}, v, d0);
    rd(2'd2, v); chk({req, " w1"}, v, d1);
    rd(2'd3, v); chk({req, " w2"}, v, d2);
  endtask

  task automatic load(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    wr(2'd1, a); wr(2'd2, b); wr(2'd3, c);
    d0 = a; d1 = b; d2 = c;
  endtask

  task automatic walk(string req);
    int n;
    run(3'd4); chk_all(req);
    n = 0;
    while (ehit && n < DEPTH + 1) begin
      run(3'd5); chk_all(req);
      n++;
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7091));
    for (int i = 0; i < DEPTH; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values, empty table, no search in progress
    chk_all("R1 reset");
    run(3'd5); chk_all("R1 next after reset gives end");
    run(3'd4); chk_all("R1 empty search start R10");

    // R7 R11: write then read hit and miss
    load(32'h0A0B_0C0D, 32'h0E0F_0064, 32'h3C05_0003);
    run(3'd1); chk_all("R4 write new");
    load(32'h0A0B_0C0D, 32'h0E0F_0064, 32'h0);
    run(3'd0); chk_all("R7 read hit R11");
    load(32'h1111_1111, 32'h2222_0001, 32'h0);
    run(3'd0); chk_all("R7 read miss invalid");

    // R11: reserved bits read back zero after load from table
    load(32'h5555_0001, 32'h6666_F007, 32'h1234_FFFD);
    run(3'd1); chk_all("R11 write reserved bits");
    run(3'd0); chk_all("R11 readback masked");

    // R4 overwrite
    load(32'h0A0B_0C0D, 32'h0E0F_0064, 32'h7702_0001);
    run(3'd1); chk_all("R4 overwrite");
    run(3'd0); chk_all("R4 overwrite readback");

    // R4 first free after erase, R5 erase absent
    load(32'hC000_0001, 32'h0000_0001, 32'h0101_0001);
    run(3'd1); chk_all("R4 third");
    load(32'h5555_0001, 32'h6666_0007, 32'h0);
    run(3'd1); chk_all("R5 erase present");
    load(32'hDEAD_0001, 32'h0000_0002, 32'h0);
    run(3'd1); chk_all("R5 erase absent no flag");
    load(32'hC000_0002, 32'h0000_0003, 32'h0202_0003);
    run(3'd1); chk_all("R4 fills first free slot");
    walk("R9 walk order");

    // R2: command write without bit 31 changes nothing
    wr(2'd0, 32'h0000_0002);
    chk_all("R2 no start without busy bit");
    walk("R2 table intact");

    // R3: writes during busy are ignored
    load(32'hBEEF_0000, 32'h0000_0005, 32'h0909_0003);
    wr(2'd0, 32'h8000_0001);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'h8000_0002);
    rd(2'd0, v);
    while (v[31]) begin @(negedge clk); rd(2'd0, v); end
    model_cmd(3'd1);
    chk_all("R3 ignored while busy");
    run(3'd0); chk_all("R3 entry survived flush attempt");

    // R8 flush, R6 full table
    run(3'd2); chk_all("R8 flush");
    run(3'd4); chk_all("R8 empty after flush");
    for (int i = 0; i < DEPTH; i++) begin
      load(32'hF000_0000 + i, 32'h0000_0010 + i, 32'h0001_0003);
      run(3'd1); chk_all("R6 fill");
    end
    load(32'hF000_00FF, 32'h0000_0020, 32'h0001_0001);
    run(3'd1); chk_all("R6 full invalid");
    walk("R6 table unchanged");
    load(32'hF000_0003, 32'h0000_0013, 32'hAA01_0001);
    run(3'd1); chk_all("R6 overwrite allowed when full");
    run(3'd2); chk_all("R8 flush full");

    // Random mix: R4 R5 R7 R9 R10
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [1:0] st;
      op = $urandom_range(0, 19);
      st = ($urandom_range(0, 3) == 0) ? 2'b00 : (($urandom_range(0, 1) == 0) ? 2'b01 : 2'b11);
      load(32'h00AA_0000 + $urandom_range(0, 5),
           {16'h1100 + 16'($urandom_range(0, 1)), 4'h0, 12'($urandom_range(1, 2))},
           {8'($urandom), 8'($urandom), 14'h0, st});
      if (op < 10)       begin run(3'd1); chk_all("R4 R5 random write"); end
      else if (op < 16)  begin run(3'd0); chk_all("R7 random read"); end
      else if (op < 19)  walk("R9 R10 random walk");
      else               begin run(3'd2); chk_all("R8 random flush"); end
    end

    finish_run();
  end
endmodule